// File: doc/BRIEF.md
# Frame-Synchronous Double-Buffered Segment Display Memory

This block holds the segment data for a multiplexed segment LCD driver in two levels. A simple register port writes and reads a staging buffer of 16 words of 32 bits: 8 common rows, 2 words per row. The segment waveform logic reads a separate display buffer through its own read port. Software cannot write the display buffer. Its contents change only when the block transfers the staging buffer into it.

After writing the staging buffer, software raises an update request. The block does not move any data at that point. It waits for the frame timing logic to signal the start of a frame while the display is enabled. It then copies one half of the words during that frame and the other half during the following frame. Which half goes first depends on whether the first frame is odd or even.

From the moment the request is taken until the last half has been copied, the staging buffer is locked. Writes that arrive while it is locked are dropped, and each one sets a sticky error flag. When the transfer ends, a done flag is set, and an interrupt follows it if the interrupt is enabled.

Top module: `dbm_display_mem`

## Requirements
- R1: After reset, the pending, done, write-error and interrupt outputs are 0, and every word of both buffers reads as 0.
- R2: A write while no update is pending stores the word in the staging buffer. `rd_data` returns the staging word selected by `rd_addr`.
- R3: Bus writes never alter the display buffer. The display buffer changes only on a frame-start cycle during a transfer.
- R4: A pulse on `upd_req` sets `upd_pend` one clock later. `upd_pend` stays 1 until the transfer finishes. Pulsing `upd_req` again while pending has no effect.
- R5: While `upd_pend` is 1, a bus write is dropped, leaving the staging word unchanged, and `wr_err` is set on the next clock. `wr_err_clr` clears `wr_err`, but a new dropped write in the same cycle wins over the clear.
- R6: The first `frame_start` with `disp_en` = 1 after a request copies half of the buffer. If `frame_odd` = 1, it copies the even-addressed words (address bit 0 = 0). If `frame_odd` = 0, it copies the odd-addressed words. The other half of the display buffer is unchanged.
- R7: The next `frame_start` with `disp_en` = 1 copies the remaining half. On that same clock, `upd_pend` clears and `upd_done` sets, so done is reached by the second enabled frame start.
- R8: While `disp_en` = 0, frame starts are ignored. `upd_pend` stays 1, `upd_done` stays 0 and the display buffer is unchanged.
- R9: `irq` = `upd_done` AND `irq_en`. A pulse on `upd_done_clr` clears `upd_done` when no transfer finishes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging buffer write strobe |
| wr_addr | input | 4 | Staging buffer write address |
| wr_data | input | 32 | Staging buffer write data |
| rd_addr | input | 4 | Staging buffer read address |
| rd_data | output | 32 | Staging buffer read data |
| upd_req | input | 1 | Update request pulse |
| upd_done_clr | input | 1 | Write-1 clear of the done flag |
| wr_err_clr | input | 1 | Write-1 clear of the write-error flag |
| irq_en | input | 1 | Done interrupt enable |
| disp_en | input | 1 | Display enable |
| frame_start | input | 1 | One-cycle frame start pulse |
| frame_odd | input | 1 | 1 when the frame starting is odd |
| disp_addr | input | 4 | Display buffer read address |
| disp_data | output | 32 | Display buffer read data |
| upd_pend | output | 1 | Update request outstanding, staging buffer locked |
| upd_done | output | 1 | Update finished (sticky) |
| wr_err | output | 1 | A write was dropped while locked (sticky) |
| irq | output | 1 | Done interrupt |

## Verification
A controller stuck in or out of its pending state shows at once at the ports. Either `upd_pend` fails to follow the request on the next clock, or a write lands in the staging buffer when it should have been dropped; a read of that address in the following cycle shows it. A wrong half selection or a copy started too early shows as display words that differ from the staging words right after the frame-start clock. The bench reads back all 16 display words after each frame start, so a fault is reported within the frame that exposes it. A missing second-frame transfer leaves `upd_done` low and half the display stale one clock after the second enabled frame start.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   typedef enum logic [1:0] {
      UPD_IDLE = 2'd0,
      UPD_WAIT = 2'd1,
      UPD_HALF = 2'd2
   } upd_state_e;
endpackage

// File: rtl/dbm_l1_bank.sv
module dbm_l1_bank #(
   parameter int WORDS = 16,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        lock,
   input  logic [AW-1:0]               wr_addr,
   input  logic [WIDTH-1:0]            wr_data,
   input  logic [AW-1:0]               rd_addr,
   output logic [WIDTH-1:0]            rd_data,
   output logic [WORDS-1:0][WIDTH-1:0] words
);
   logic [WORDS-1:0][WIDTH-1:0] mem_q;
   logic                        wr_ok;

   assign wr_ok = wr_en && !lock;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[i] <= '0;
         end else if (wr_ok && (wr_addr == AW'(i))) begin
            mem_q[i] <= wr_data;
         end
      end

      // R5
      locked_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(mem_q[i]) |-> $past(!lock));
   end

   assign rd_data = mem_q[rd_addr];
   assign words   = mem_q;
endmodule

// File: rtl/dbm_l2_bank.sv
module dbm_l2_bank #(
   parameter int WORDS       = 16,
   parameter int WIDTH       = 32,
   parameter bit HALF_BY_MSB = 1'b0,
   localparam int AW = $clog2(WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        copy_even,
   input  logic                        copy_odd,
   input  logic [WORDS-1:0][WIDTH-1:0] src,
   input  logic [AW-1:0]               disp_addr,
   output logic [WIDTH-1:0]            disp_data
);
   logic [WORDS-1:0][WIDTH-1:0] disp_q;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic take;
      if (HALF_BY_MSB) begin : g_msb
         localparam bit IN_ODD = (i >= WORDS / 2);
         assign take = IN_ODD ? copy_odd : copy_even;
      end else begin : g_lsb
         localparam bit IN_ODD = (i % 2) == 1;
         assign take = IN_ODD ? copy_odd : copy_even;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            disp_q[i] <= '0;
         end else if (take) begin
            disp_q[i] <= src[i];
         end
      end

      // R3
      disp_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(disp_q[i]) |-> $past(copy_even || copy_odd));
   end

   assign disp_data = disp_q[disp_addr];
endmodule

// File: rtl/dbm_update_ctrl.sv
module dbm_update_ctrl
   import dbm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic upd_req,
   input  logic upd_done_clr,
   input  logic wr_err_clr,
   input  logic wr_en,
   input  logic disp_en,
   input  logic frame_start,
   input  logic frame_odd,
   output logic lock,
   output logic copy_even,
   output logic copy_odd,
   output logic upd_done,
   output logic wr_err
);
   upd_state_e state_q, state_d;
   logic       even_first_q, even_first_d;
   logic       tick, finish;
   logic       done_q, err_q;

   assign tick = frame_start && disp_en;

   always_comb begin
      state_d      = state_q;
      even_first_d = even_first_q;
      copy_even    = 1'b0;
      copy_odd     = 1'b0;
      finish       = 1'b0;
      unique case (state_q)
         UPD_IDLE: begin
            if (upd_req) state_d = UPD_WAIT;
         end
         UPD_WAIT: begin
            if (tick) begin
               copy_even    = frame_odd;
               copy_odd     = !frame_odd;
               even_first_d = frame_odd;
               state_d      = UPD_HALF;
            end
         end
         UPD_HALF: begin
            if (tick) begin
               copy_even = !even_first_q;
               copy_odd  = even_first_q;
               finish    = 1'b1;
               state_d   = UPD_IDLE;
            end
         end
         default: state_d = UPD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= UPD_IDLE;
         even_first_q <= 1'b0;
         done_q       <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         state_q      <= state_d;
         even_first_q <= even_first_d;
         if (finish)            done_q <= 1'b1;
         else if (upd_done_clr) done_q <= 1'b0;
         if (wr_en && lock)     err_q  <= 1'b1;
         else if (wr_err_clr)   err_q  <= 1'b0;
      end
   end

   assign lock     = (state_q != UPD_IDLE);
   assign upd_done = done_q;
   assign wr_err   = err_q;

   // R4
   repeat_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_req && lock && !tick) |=> lock);
   // R8
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !disp_en) |=> (lock && $stable(done_q)));
   // R7
   done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> done_q);
   // R5
   dropped_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock) |=> err_q);
   // R6
   one_half_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(copy_even && copy_odd));
endmodule

// File: rtl/dbm_display_mem.sv
module dbm_display_mem #(
   parameter int WORDS       = 16,
   parameter int WIDTH       = 32,
   parameter bit HALF_BY_MSB = 1'b0,
   localparam int AW = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             upd_req,
   input  logic             upd_done_clr,
   input  logic             wr_err_clr,
   input  logic             irq_en,
   input  logic             disp_en,
   input  logic             frame_start,
   input  logic             frame_odd,
   input  logic [AW-1:0]    disp_addr,
   output logic [WIDTH-1:0] disp_data,
   output logic             upd_pend,
   output logic             upd_done,
   output logic             wr_err,
   output logic             irq
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two and at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be positive");
   end

   logic                        lock;
   logic                        copy_even, copy_odd;
   logic [WORDS-1:0][WIDTH-1:0] l1_words;

   dbm_update_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd_req      (upd_req),
      .upd_done_clr (upd_done_clr),
      .wr_err_clr   (wr_err_clr),
      .wr_en        (wr_en),
      .disp_en      (disp_en),
      .frame_start  (frame_start),
      .frame_odd    (frame_odd),
      .lock         (lock),
      .copy_even    (copy_even),
      .copy_odd     (copy_odd),
      .upd_done     (upd_done),
      .wr_err       (wr_err)
   );

   dbm_l1_bank #(.WORDS(WORDS), .WIDTH(WIDTH)) u_l1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .lock    (lock),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .words   (l1_words)
   );

   dbm_l2_bank #(.WORDS(WORDS), .WIDTH(WIDTH), .HALF_BY_MSB(HALF_BY_MSB)) u_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .copy_even (copy_even),
      .copy_odd  (copy_odd),
      .src       (l1_words),
      .disp_addr (disp_addr),
      .disp_data (disp_data)
   );

   assign upd_pend = lock;
   assign irq      = upd_done && irq_en;

   // R9
   irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done_clr && !$rose(upd_done)) |=> !irq || $past(lock));
endmodule

// File: tb/dbm_display_mem_tb.sv
module dbm_display_mem_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS = 16;
   localparam int WIDTH = 32;

   typedef struct {
      string       req;
      int          kind;
      int          addr;
      logic [31:0] exp;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, upd_req = 0, upd_done_clr = 0, wr_err_clr = 0;
   logic irq_en = 0, disp_en = 0, frame_start = 0, frame_odd = 0;
   logic [3:0] wr_addr = 0, rd_addr = 0, disp_addr = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] rd_data, disp_data;
   logic upd_pend, upd_done, wr_err, irq;

   int checks = 0;
   int errors = 0;
   item_t sb[$];
   logic [31:0] m_l1 [WORDS];
   logic [31:0] m_l2 [WORDS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   dbm_display_mem u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .upd_req(upd_req), .upd_done_clr(upd_done_clr),
      .wr_err_clr(wr_err_clr), .irq_en(irq_en), .disp_en(disp_en), .frame_start(frame_start),
      .frame_odd(frame_odd), .disp_addr(disp_addr), .disp_data(disp_data), .upd_pend(upd_pend),
      .upd_done(upd_done), .wr_err(wr_err), .irq(irq)
   );

   function automatic logic [31:0] pat_a(int i);
      return (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000;
   endfunction

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(string req, int kind, int addr, logic [31:0] exp);
      item_t it;
      it.req = req; it.kind = kind; it.addr = addr; it.exp = exp;
      sb.push_back(it);
   endtask

   task automatic push_flags(string req, logic p, logic d, logic e, logic q);
      push(req, 2, 0, 32'(p));
      push(req, 3, 0, 32'(d));
      push(req, 4, 0, 32'(e));
      push(req, 5, 0, 32'(q));
   endtask

   task automatic push_bufs(string req_l1, string req_l2);
      for (int i = 0; i < WORDS; i++) begin
         if (req_l1 != "") push(req_l1, 0, i, m_l1[i]);
         push(req_l2, 1, i, m_l2[i]);
      end
   endtask

   // monitor: pops expected items and compares them against the ports
   task automatic drain();
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         rd_addr   = 4'(it.addr);
         disp_addr = 4'(it.addr);
         #1;
         case (it.kind)
            0: act = rd_data;
            1: act = disp_data;
            2: act = 32'(upd_pend);
            3: act = 32'(upd_done);
            4: act = 32'(wr_err);
            default: act = 32'(irq);
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                     it.req, it.kind, it.addr, act, it.exp);
         end
      end
   endtask

   task automatic bus_write(int a, logic [31:0] d);
      wr_en = 1; wr_addr = 4'(a); wr_data = d;
      cyc();
      wr_en = 0;
   endtask

   task automatic frame(logic odd);
      frame_start = 1; frame_odd = odd;
      cyc();
      frame_start = 0;
   endtask

   task automatic model_copy(bit odd_half);
      for (int i = 0; i < WORDS; i++)
         if ((i % 2 == 1) == odd_half) m_l2[i] = m_l1[i];
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) begin m_l1[i] = '0; m_l2[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // R1 reset state
      push_flags("R1", 0, 0, 0, 0);
      push_bufs("R1", "R1");
      drain();

      // R2 idle writes
      for (int i = 0; i < WORDS; i++) begin
         bus_write(i, pat_a(i));
         m_l1[i] = pat_a(i);
      end
      push_bufs("R2", "R3");
      drain();

      // R4 request with display off
      upd_req = 1; cyc(); upd_req = 0;
      push_flags("R4", 1, 0, 0, 0);
      drain();
      // R5 blocked write
      bus_write(3, 32'hDEAD_BEEF);
      push("R5", 0, 3, m_l1[3]);
      push("R3", 1, 3, 32'h0);
      push_flags("R5", 1, 0, 1, 0);
      drain();
      // R4 repeated request has no effect
      upd_req = 1; cyc(); upd_req = 0;
      push_flags("R4", 1, 0, 1, 0);
      drain();
      // R8 frames ignored while disabled
      frame(1'b1); frame(1'b0);
      push_flags("R8", 1, 0, 1, 0);
      push_bufs("", "R8");
      drain();
      // R5 clear error; same-cycle set wins
      wr_err_clr = 1; wr_en = 1; wr_addr = 4'd5; wr_data = 32'h1234_5678;
      cyc();
      wr_en = 0;
      push("R5", 4, 0, 32'd1);
      push("R5", 0, 5, m_l1[5]);
      drain();
      cyc();
      wr_err_clr = 0;
      push("R5", 4, 0, 32'd0);
      drain();

      // R6 first enabled frame (odd) copies even-addressed words
      disp_en = 1; irq_en = 1;
      cyc();
      push_bufs("", "R3");
      drain();
      frame(1'b1);
      model_copy(1'b0);
      push_bufs("", "R6");
      push_flags("R6", 1, 0, 0, 0);
      drain();
      // R7 second frame finishes
      frame(1'b0);
      model_copy(1'b1);
      push_bufs("R7", "R7");
      push_flags("R7", 0, 1, 0, 1);
      drain();
      // R9 interrupt enable gates irq, clear drops done
      irq_en = 0; #1;
      push("R9", 5, 0, 32'd0);
      drain();
      upd_done_clr = 1; cyc(); upd_done_clr = 0;
      push_flags("R9", 0, 0, 0, 0);
      drain();

      // second update, first frame even -> odd-addressed words first
      irq_en = 1;
      for (int i = 0; i < WORDS; i++) begin
         bus_write(i, ~pat_a(i));
         m_l1[i] = ~pat_a(i);
      end
      push_bufs("R2", "R3");
      drain();
      upd_req = 1; cyc(); upd_req = 0;
      frame(1'b0);
      model_copy(1'b1);
      push_bufs("", "R6");
      drain();
      frame(1'b1);
      model_copy(1'b0);
      push_bufs("", "R7");
      push_flags("R7", 0, 1, 0, 1);
      drain();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule